// File: doc/BRIEF.md
# Predictive Synchronous-Rectifier Gate Timer

This block produces the gate enable for a secondary-side synchronous rectifier. It runs on a fast sampling clock. It takes three inputs: a clock input from the transformer secondary that is already synchronized and thresholded, a two-bit anticipation select, and the flag from the reverse-current comparator. The gate is driven while the secondary clock input is low. It turns on one tick after the falling transition is sampled.

The block does not wait for the rising transition to remove the gate. It counts the length of every low phase in ticks. On the next cycle it releases the gate a selected number of ticks before that length runs out, so the rectifier is already off when the primary switch turns on. The measurement is redone every cycle, so the timing follows changes in the switching period.

When no trusted measurement exists, the gate falls back to turning off on the sampled rising transition. This covers the first cycle after reset and the cycle after a lost clock. The comparator flag can block turn-on and can end conduction early, but never before a minimum on-time has elapsed.

Top module: `sr_gate_timer`

## Requirements
- R1: `gateOn` is 0 while `rstN` is low. After reset, `gateOn` stays 0 until a falling transition of `syncIn` (a sample of 1 followed by a sample of 0) has been seen. A `syncIn` that is already low at reset release does not count as a falling transition.
- R2: The gate can turn on only on the first low sample after a falling transition. `gateOn` is then 1 on the next tick and stays high without gaps until it turns off once. It never turns on again later in the same low phase.
- R3: Any sample with `syncIn`=1 makes `gateOn` 0 on the next tick. It overrides every other condition.
- R4: When no valid length is stored, the gate stays on for every low sample. This applies to the first cycle after reset and to the cycle after a lost clock. The gate then turns off on the rising transition, so it is high for exactly L ticks, where L is the number of low samples.
- R5: When a valid length P from the previous low phase is stored, the gate is high for low-sample indices 1 to P−A, where A is the anticipation in ticks. If the current phase rises before that point, the rise cuts the gate short.
- R6: The anticipation select `antSel` maps as follows: 00 gives ANT0 ticks (default 1), 01 gives ANT1 (default 2), and both 10 and 11 give ANT2 (default 3).
- R7: If the stored valid length P is less than A+MIN_ON, the gate stays 0 for the whole low phase.
- R8: If `inhEn` is 0 on the falling-transition sample, the gate does not turn on in that phase. While the gate is on and past its minimum on-time, a sample with `inhEn`=0 makes `gateOn` 0 on the next tick.
- R9: Once on, the gate stays high for at least MIN_ON ticks (default 4) regardless of `inhEn`. Only R3 or R10 can end it sooner.
- R10: The low-phase counter saturates at 2^CNT_W−1. Reaching that value is treated as a lost clock: it forces the gate off and marks the measurement invalid.
- R11: Every rising transition stores the length of the low phase just ended, so each new phase is timed from the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (about 15 MHz in the target use) |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Synchronized, thresholded secondary clock input |
| antSel | input | 2 | Anticipation select code |
| inhEn | input | 1 | 1 when the reverse-current comparator allows conduction |
| gateOn | output | 1 | Gate enable for the rectifier switch |

## Verification
The assertions assume that `syncIn` and `inhEn` are already synchronous to `clk`. They also assume that `antSel` does not change inside a low phase. The bench therefore drives every input half a period away from the sampling edge. It changes `antSel` only at the start of a low phase and keeps its one long phase within the counter range except on purpose. The property for R2 relies on a turn-on being preceded by a sampled high level, which stimulus with whole phases always provides.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  // Strobes issued by the control to the datapath each tick
  typedef struct packed {
    logic startLow;   // first low sample of a phase
    logic countLow;   // syncIn sampled low
    logic latchLen;   // rising transition: store the phase length
    logic startOn;    // gate turns on this tick
    logic countOn;    // gate held on this tick
  } strobes_t;
endpackage

// File: rtl/sr_gate_dp.sv
module sr_gate_dp
  import sr_gate_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ANT0   = 1,
  parameter int ANT1   = 2,
  parameter int ANT2   = 3,
  parameter int MIN_ON = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic [1:0] antSel,
  input  strobes_t   strobe,
  output logic       fallEdge,
  output logic       riseEdge,
  output logic       lost,
  output logic       lastValid,
  output logic       predictOk,
  output logic       inWindow,
  output logic       minDone
);
  localparam int ON_W = $clog2(MIN_ON + 1);
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);
  localparam logic [CNT_W:0]   MINOE = (CNT_W+1)'(MIN_ON);
  localparam logic [ON_W-1:0]  MINOC = ON_W'(MIN_ON);

  logic             syncPrev;
  logic [CNT_W-1:0] lowCnt, kNow, lastLen, antTicks, cutoff;
  logic [ON_W-1:0]  onCnt;

  assign fallEdge = syncPrev & ~syncIn;
  assign riseEdge = ~syncPrev & syncIn;

  // Index of the current low sample (0 while no phase is being tracked)
  always_comb begin
    if (strobe.startLow)      kNow = CONE;
    else if (lowCnt == '0)    kNow = '0;
    else if (lowCnt == CMAX)  kNow = CMAX;
    else                      kNow = lowCnt + CONE;
  end

  assign lost = ~syncIn & (kNow == CMAX);

  always_comb begin
    unique case (antSel)
      2'b00:   antTicks = CNT_W'(ANT0);
      2'b01:   antTicks = CNT_W'(ANT1);
      default: antTicks = CNT_W'(ANT2);
    endcase
  end

  assign cutoff    = lastLen - antTicks;
  assign predictOk = {1'b0, lastLen} >= ({1'b0, antTicks} + MINOE);
  assign inWindow  = kNow <= cutoff;
  assign minDone   = onCnt >= MINOC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev  <= 1'b0;
      lowCnt    <= '0;
      lastLen   <= '0;
      lastValid <= 1'b0;
      onCnt     <= '0;
    end else begin
      syncPrev <= syncIn;
      if (strobe.countLow) lowCnt <= kNow;
      if (strobe.latchLen) begin
        lastLen   <= lowCnt;
        lastValid <= (lowCnt != '0) && (lowCnt != CMAX);
      end else if (lost) begin
        lastValid <= 1'b0;
      end
      if (strobe.startOn)                      onCnt <= ON_W'(1);
      else if (strobe.countOn && !minDone)     onCnt <= onCnt + ON_W'(1);
    end
  end

  // R10: a stored valid length is never empty or saturated
  assert_len_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    lastValid |-> (lastLen != '0 && lastLen != CMAX));

  // R11: a rising transition after a tracked, unsaturated phase yields a valid length
  assert_len_capture_R11: assert property (@(posedge clk) disable iff (!rstN)
    (riseEdge && lowCnt != '0 && lowCnt != CMAX) |=> lastValid);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     syncIn,
  input  logic     inhEn,
  input  logic     fallEdge,
  input  logic     riseEdge,
  input  logic     lost,
  input  logic     lastValid,
  input  logic     predictOk,
  input  logic     inWindow,
  input  logic     minDone,
  output strobes_t strobe,
  output logic     gateOn
);
  logic allowPred, gateNext;

  // Edge mode when no valid length is stored; otherwise the prediction window
  assign allowPred = ~lastValid | (predictOk & inWindow);

  always_comb begin
    if (syncIn || lost)  gateNext = 1'b0;
    else if (fallEdge)   gateNext = inhEn & allowPred;
    else if (gateOn)     gateNext = (inhEn | ~minDone) & allowPred;
    else                 gateNext = 1'b0;
  end

  always_comb begin
    strobe.startLow = fallEdge;
    strobe.countLow = ~syncIn;
    strobe.latchLen = riseEdge;
    strobe.startOn  = fallEdge & gateNext;
    strobe.countOn  = gateOn & gateNext & ~fallEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) gateOn <= 1'b0;
    else       gateOn <= gateNext;
  end

  assert_off_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> !gateOn);

  assert_on_at_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(fallEdge));

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(inhEn));

  assert_lost_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    lost |=> !gateOn);

  assert_min_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && !minDone && !syncIn && !lost && !fallEdge && allowPred) |=> gateOn);
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
  import sr_gate_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ANT0   = 1,
  parameter int ANT1   = 2,
  parameter int ANT2   = 3,
  parameter int MIN_ON = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic [1:0] antSel,
  input  logic       inhEn,
  output logic       gateOn
);
  strobes_t strobe;
  logic fallEdge, riseEdge, lost, lastValid, predictOk, inWindow, minDone;

  sr_gate_dp #(
    .CNT_W(CNT_W), .ANT0(ANT0), .ANT1(ANT1), .ANT2(ANT2), .MIN_ON(MIN_ON)
  ) uDp (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .antSel(antSel), .strobe(strobe),
    .fallEdge(fallEdge), .riseEdge(riseEdge), .lost(lost), .lastValid(lastValid),
    .predictOk(predictOk), .inWindow(inWindow), .minDone(minDone)
  );

  sr_gate_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .inhEn(inhEn),
    .fallEdge(fallEdge), .riseEdge(riseEdge), .lost(lost), .lastValid(lastValid),
    .predictOk(predictOk), .inWindow(inWindow), .minDone(minDone),
    .strobe(strobe), .gateOn(gateOn)
  );
endmodule

// File: tb/tb_sr_gate_timer.sv
`timescale 1ns/1ps
module tb_sr_gate_timer;
  logic clk = 1'b0;
  logic rstN, syncIn, inhEn, gateOn;
  logic [1:0] antSel;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sr_gate_timer dut (.clk(clk), .rstN(rstN), .syncIn(syncIn), .antSel(antSel),
                     .inhEn(inhEn), .gateOn(gateOn));

  // Vectors: low samples, high samples, select, inhibit-drop index (0 = never), expected on ticks
  localparam int NV = 14;
  localparam int VLOW [NV] = '{20, 20, 20, 20, 20, 30, 12, 12, 6, 6, 6, 20, 20, 20};
  localparam int VHIGH[NV] = '{10, 10, 10, 10, 10, 10,  8,  8, 8, 8, 8, 10, 10, 10};
  localparam int VSEL [NV] = '{ 0,  0,  1,  2,  3,  0,  0,  2, 2, 2, 1,  0,  0,  0};
  localparam int VDROP[NV] = '{ 0,  0,  0,  0,  0,  0,  0,  0, 0, 0, 0,  2, 10,  1};
  localparam int VEXP [NV] = '{20, 19, 18, 17, 17, 19, 12,  9, 6, 0, 4,  4,  9,  0};

  function automatic string vtag(int n);
    case (n)
      0: return "R4";
      1: return "R5";
      2, 3, 4: return "R6";
      5, 6: return "R11";
      7, 8: return "R5";
      9: return "R7";
      10: return "R7";
      11: return "R9";
      12: return "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic check(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one sample at the falling clock edge; return the gate for that sample
  task automatic tick(input logic s, input logic i, output logic g);
    syncIn = s;
    inhEn  = i;
    @(posedge clk);
    @(negedge clk);
    g = gateOn;
  endtask

  task automatic runCycle(int lowLen, int highLen, int sel, int dropAt,
                          output int onCnt, output int lastOn, output int highOn);
    logic g;
    onCnt = 0; lastOn = 0; highOn = 0;
    antSel = 2'(sel);
    for (int k = 1; k <= lowLen; k++) begin
      tick(1'b0, (dropAt == 0) || (k < dropAt), g);
      if (g) begin onCnt++; lastOn = k; end
    end
    for (int j = 1; j <= highLen; j++) begin
      tick(1'b1, 1'b1, g);
      if (g) highOn++;
    end
  endtask

  initial begin
    int onCnt, lastOn, highOn, lowOn;
    logic g;
    rstN = 1'b0; syncIn = 1'b0; inhEn = 1'b1; antSel = 2'b00;
    repeat (3) @(negedge clk);
    check(int'(gateOn), 0, "R1", "gate during reset");
    rstN = 1'b1;
    // R1: low at reset release is not a falling transition
    lowOn = 0;
    for (int k = 0; k < 10; k++) begin
      tick(1'b0, 1'b1, g);
      if (g) lowOn++;
    end
    check(lowOn, 0, "R1", "gate on without a falling transition");
    for (int k = 0; k < 10; k++) tick(1'b1, 1'b1, g);

    for (int n = 0; n < NV; n++) begin
      runCycle(VLOW[n], VHIGH[n], VSEL[n], VDROP[n], onCnt, lastOn, highOn);
      check(onCnt, VEXP[n], vtag(n), $sformatf("on ticks, vector %0d", n));
      if (VEXP[n] > 0)
        check(lastOn, onCnt, "R2", $sformatf("gate not one run from sample 1, vector %0d", n));
      check(highOn, 0, "R3", $sformatf("gate during high phase, vector %0d", n));
    end

    // R10: lost clock; predicted from 20 then saturation invalidates the measurement
    runCycle(1100, 10, 0, 0, onCnt, lastOn, highOn);
    check(onCnt, 19, "R10", "on ticks in long phase");
    check(lastOn, 19, "R10", "last on sample in long phase");
    runCycle(20, 10, 0, 0, onCnt, lastOn, highOn);
    check(onCnt, 20, "R10", "edge-based fallback after lost clock");
    runCycle(20, 10, 0, 0, onCnt, lastOn, highOn);
    check(onCnt, 19, "R11", "prediction resumes");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule